// File: doc/BRIEF.md
# Bus Hand-Over Arbiter with Shared Chip-Select Decode

This block lets an external bus master take over a processor's memory interface. An active-low request from outside is first synchronized. The core is then asked to hold at its next instruction boundary. Only after the core reports that it is idle does the block grant the bus. While the grant lasts, the block turns off the local drivers for the address, the strobes and the data. It also steers the external master's address and request strobes into the on-chip chip-select decoder, so the four chip selects keep working for the new owner.

The core and the pads are outside the block. The core is modelled by a hold output and an idle input. The pads are modelled by per-group output enables and by the pad input values. All interfaces are plain control and status pins; there is no streaming data path, so no valid/ready back-pressure applies. All strobes and the acknowledge are active low. The output enables and the hold are active high.

Top module: `busarb_top`

## Requirements
- R1: After reset, `bus_ack_n` is 1 and `core_hold` is 0. `addr_oe`, `ctl_oe` and `rw_oe` are all 1.
- R2: `ext_req_n` passes through a two-flop synchronizer. Driven low, it raises `core_hold` at the third rising edge, with `bus_ack_n` still 1. The acknowledge waits as long as `core_idle` stays 0.
- R3: `bus_ack_n` falls only at a rising edge where `core_hold` and `core_idle` were both 1. It does so on the first such edge.
- R4: While `bus_ack_n` is 0, `addr_oe`, `ctl_oe`, `rw_oe` and `data_oe` are all 0, whatever the value of `cpu_data_oe`. `core_hold` stays 1.
- R5: While `bus_ack_n` is 0, the decoder uses `ext_addr`, `ext_mreq_n` and `ext_iorq_n`, and the core's address and strobes have no effect on `cs_n`. At all other times it uses `cpu_addr`, `cpu_mreq_n` and `cpu_iorq_n`.
- R6: When `ext_req_n` returns high, `bus_ack_n` rises at the third edge with the drivers still off. At the next edge the drivers are re-enabled and `core_hold` drops, both in the same cycle.
- R7: If the request is withdrawn before `core_idle` is seen, `core_hold` drops at the third edge after `ext_req_n` rises, and no acknowledge is ever given.
- R8: Chip select g (bit g of `cs_n`, low = selected) asserts when two conditions hold. The first is that the selected address lies within its inclusive bounds. The defaults are: select 0 memory 0x000000–0x07FFFF; select 1 memory 0x080000–0x0FFFFF; select 2 memory 0xC00000–0xFFFFFF; select 3 I/O 0x000000–0x0000FF. The second is that the strobe for its type is low: memory-request for memory selects, I/O-request for I/O selects. With both strobes high, `cs_n` is all ones.
- R9: Outside the grant, `data_oe` follows `cpu_data_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | External bus request, active low, asynchronous |
| bus_ack_n | output | 1 | Bus granted to external master, active low |
| core_hold | output | 1 | Asks the core to stop at its next instruction boundary |
| core_idle | input | 1 | Core reports it has stopped and released the bus |
| cpu_addr | input | 24 | Core's address |
| cpu_mreq_n | input | 1 | Core's memory-request strobe |
| cpu_iorq_n | input | 1 | Core's I/O-request strobe |
| cpu_data_oe | input | 1 | Core wants to drive the data bus |
| ext_addr | input | 24 | Address pad input value |
| ext_mreq_n | input | 1 | Memory-request pad input value |
| ext_iorq_n | input | 1 | I/O-request pad input value |
| addr_oe | output | 1 | Address pad output enable |
| ctl_oe | output | 1 | Memory/I/O request pad output enables |
| rw_oe | output | 1 | Read, write and instruction-read pad output enables |
| data_oe | output | 1 | Data pad output enable |
| cs_n | output | 4 | Chip-select outputs, active low |

## Verification
The bench builds the block with its default parameters. These are four chip selects over a 24-bit address, with two adjacent memory windows, a high memory window and a low I/O window. The adjacent windows place their shared boundary (0x07FFFF/0x080000) within reach of one vector pair. The I/O window overlaps select 0, so a single address tells the strobe types apart. The default two-stage synchronizer fixes the request-to-hold latency at three edges, and the directed sequences check it to the cycle.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  typedef enum logic [1:0] {
    ST_OWNED = 2'd0,
    ST_WAIT_BOUNDARY = 2'd1,
    ST_GRANTED = 2'd2,
    ST_RETURN = 2'd3
  } arb_state_t;
endpackage

// File: rtl/busarb_sync.sv
module busarb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/busarb_fsm.sv
module busarb_fsm
  import busarb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic core_idle,
  output logic core_hold,
  output logic ack_n,
  output logic drv_en,
  output logic ext_sel
);
  arb_state_t st, st_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OWNED;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_OWNED:         if (req) st_nx = ST_WAIT_BOUNDARY;
      ST_WAIT_BOUNDARY: if (!req) st_nx = ST_OWNED;
                        else if (core_idle) st_nx = ST_GRANTED;
      ST_GRANTED:       if (!req) st_nx = ST_RETURN;
      ST_RETURN:        st_nx = ST_OWNED;
      default:          st_nx = ST_OWNED;
    endcase
  end

  // Moore outputs: drivers stay off through the return cycle
  assign core_hold = (st != ST_OWNED);
  assign ack_n     = (st != ST_GRANTED);
  assign drv_en    = (st == ST_OWNED) || (st == ST_WAIT_BOUNDARY);
  assign ext_sel   = (st == ST_GRANTED);
endmodule

// File: rtl/busarb_csdec.sv
module busarb_csdec #(
  parameter int ADDR_W = 24,
  parameter int NUM_CS = 4,
  parameter logic [NUM_CS*ADDR_W-1:0] CS_LO = '0,
  parameter logic [NUM_CS*ADDR_W-1:0] CS_HI = '1,
  parameter logic [NUM_CS-1:0] CS_IO = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mreq_n,
  input  logic              iorq_n,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    localparam logic [ADDR_W-1:0] LO = CS_LO[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] HI = CS_HI[g*ADDR_W +: ADDR_W];
    logic [ADDR_W:0] d_lo, d_hi;
    logic            strobe;
    // borrow-free subtraction means "not below" the bound
    assign d_lo   = {1'b0, addr} - {1'b0, LO};
    assign d_hi   = {1'b0, HI} - {1'b0, addr};
    assign strobe = CS_IO[g] ? !iorq_n : !mreq_n;
    assign cs_n[g] = !(strobe && !d_lo[ADDR_W] && !d_hi[ADDR_W]);
  end
endmodule

// File: rtl/busarb_top.sv
module busarb_top #(
  parameter int ADDR_W = 24,
  parameter int NUM_CS = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [NUM_CS*ADDR_W-1:0] CS_LO =
    {24'h000000, 24'hC00000, 24'h080000, 24'h000000},
  parameter logic [NUM_CS*ADDR_W-1:0] CS_HI =
    {24'h0000FF, 24'hFFFFFF, 24'h0FFFFF, 24'h07FFFF},
  parameter logic [NUM_CS-1:0] CS_IO = 4'b1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_req_n,
  output logic              bus_ack_n,
  output logic              core_hold,
  input  logic              core_idle,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_mreq_n,
  input  logic              cpu_iorq_n,
  input  logic              cpu_data_oe,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              ext_mreq_n,
  input  logic              ext_iorq_n,
  output logic              addr_oe,
  output logic              ctl_oe,
  output logic              rw_oe,
  output logic              data_oe,
  output logic [NUM_CS-1:0] cs_n
);
  logic req_s, drv_en, ext_sel;
  logic [ADDR_W-1:0] dec_addr;
  logic dec_mreq_n, dec_iorq_n;

  busarb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(!ext_req_n), .d_out(req_s)
  );

  busarb_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req_s), .core_idle(core_idle),
    .core_hold(core_hold), .ack_n(bus_ack_n), .drv_en(drv_en), .ext_sel(ext_sel)
  );

  assign dec_addr   = ext_sel ? ext_addr   : cpu_addr;
  assign dec_mreq_n = ext_sel ? ext_mreq_n : cpu_mreq_n;
  assign dec_iorq_n = ext_sel ? ext_iorq_n : cpu_iorq_n;

  busarb_csdec #(
    .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .CS_LO(CS_LO), .CS_HI(CS_HI), .CS_IO(CS_IO)
  ) u_dec (
    .addr(dec_addr), .mreq_n(dec_mreq_n), .iorq_n(dec_iorq_n), .cs_n(cs_n)
  );

  assign addr_oe = drv_en;
  assign ctl_oe  = drv_en;
  assign rw_oe   = drv_en;
  assign data_oe = drv_en && cpu_data_oe;
endmodule

// File: rtl/busarb_chk.sv
module busarb_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ack_n,
  input logic              core_hold,
  input logic              core_idle,
  input logic              addr_oe,
  input logic              ctl_oe,
  input logic              rw_oe,
  input logic              data_oe,
  input logic              cpu_mreq_n,
  input logic              cpu_iorq_n,
  input logic              ext_mreq_n,
  input logic              ext_iorq_n,
  input logic [NUM_CS-1:0] cs_n
);
  p_hold_under_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n |-> core_hold);

  p_ack_after_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ack_n) |-> ($past(core_idle) && $past(core_hold)));

  p_pads_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack_n |-> (!addr_oe && !ctl_oe && !rw_oe && !data_oe));

  p_release_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack_n) |-> (!addr_oe && core_hold) ##1 (addr_oe && !core_hold));

  p_no_strobe_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack_n ? (cpu_mreq_n && cpu_iorq_n) : (ext_mreq_n && ext_iorq_n))
      |-> (cs_n == '1));
endmodule

bind busarb_top busarb_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ack_n(bus_ack_n), .core_hold(core_hold),
  .core_idle(core_idle), .addr_oe(addr_oe), .ctl_oe(ctl_oe), .rw_oe(rw_oe),
  .data_oe(data_oe), .cpu_mreq_n(cpu_mreq_n), .cpu_iorq_n(cpu_iorq_n),
  .ext_mreq_n(ext_mreq_n), .ext_iorq_n(ext_iorq_n), .cs_n(cs_n)
);

// File: tb/busarb_top_bench.sv
module busarb_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_req_n = 1'b1, core_idle = 1'b0;
  logic [23:0] cpu_addr = '0, ext_addr = '0;
  logic cpu_mreq_n = 1'b1, cpu_iorq_n = 1'b1, cpu_data_oe = 1'b0;
  logic ext_mreq_n = 1'b1, ext_iorq_n = 1'b1;
  logic bus_ack_n, core_hold, addr_oe, ctl_oe, rw_oe, data_oe;
  logic [3:0] cs_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  busarb_top u_busarb_top (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .bus_ack_n(bus_ack_n),
    .core_hold(core_hold), .core_idle(core_idle), .cpu_addr(cpu_addr),
    .cpu_mreq_n(cpu_mreq_n), .cpu_iorq_n(cpu_iorq_n), .cpu_data_oe(cpu_data_oe),
    .ext_addr(ext_addr), .ext_mreq_n(ext_mreq_n), .ext_iorq_n(ext_iorq_n),
    .addr_oe(addr_oe), .ctl_oe(ctl_oe), .rw_oe(rw_oe), .data_oe(data_oe),
    .cs_n(cs_n)
  );

  // {addr[23:0], mreq_n, iorq_n, expected cs_n[3:0]}
  localparam int NV = 11;
  localparam logic [29:0] VEC [NV] = '{
    {24'h000000, 1'b0, 1'b1, 4'b1110},
    {24'h07FFFF, 1'b0, 1'b1, 4'b1110},
    {24'h080000, 1'b0, 1'b1, 4'b1101},
    {24'h0FFFFF, 1'b0, 1'b1, 4'b1101},
    {24'h100000, 1'b0, 1'b1, 4'b1111},
    {24'hBFFFFF, 1'b0, 1'b1, 4'b1111},
    {24'hC00000, 1'b0, 1'b1, 4'b1011},
    {24'h000010, 1'b1, 1'b0, 4'b0111},
    {24'h000100, 1'b1, 1'b0, 4'b1111},
    {24'h000010, 1'b1, 1'b1, 4'b1111},
    {24'h000010, 1'b0, 1'b0, 4'b0110}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1", "bus_ack_n", bus_ack_n, 1);
    chk("R1", "core_hold", core_hold, 0);
    chk("R1", "oe", {addr_oe, ctl_oe, rw_oe}, 3'b111);

    // R8 decoder table, core owns the bus
    for (int i = 0; i < NV; i++) begin
      {cpu_addr, cpu_mreq_n, cpu_iorq_n} = VEC[i][29:4];
      #1;
      chk("R8", $sformatf("cs_n vec %0d", i), cs_n, VEC[i][3:0]);
      cyc(1);
    end

    // R9 data_oe follows the core outside the grant
    cpu_data_oe = 1'b1; #1;
    chk("R9", "data_oe on", data_oe, 1);
    cyc(1);

    // R2 request, core busy
    ext_req_n = 1'b0;
    cyc(2);
    chk("R2", "hold before 3rd edge", core_hold, 0);
    cyc(1);
    chk("R2", "hold at 3rd edge", core_hold, 1);
    chk("R2", "ack waits", bus_ack_n, 1);
    cyc(3);
    chk("R2", "ack waits idle", bus_ack_n, 1);
    chk("R2", "drivers on while waiting", addr_oe, 1);

    // R3 core idle -> grant next edge
    core_idle = 1'b1;
    cyc(1);
    chk("R3", "ack after idle", bus_ack_n, 0);
    // R4 pads off in grant
    chk("R4", "oe off", {addr_oe, ctl_oe, rw_oe, data_oe}, 4'b0000);
    chk("R4", "hold kept", core_hold, 1);

    // R5 external source drives decode, core inputs ignored
    cpu_addr = 24'h000000; cpu_mreq_n = 1'b0; cpu_iorq_n = 1'b1;
    ext_addr = 24'h080000; ext_mreq_n = 1'b0; ext_iorq_n = 1'b1;
    #1;
    chk("R5", "ext mem select", cs_n, 4'b1101);
    ext_addr = 24'h000020; ext_mreq_n = 1'b1; ext_iorq_n = 1'b0;
    #1;
    chk("R5", "ext io select", cs_n, 4'b0111);
    ext_mreq_n = 1'b1; ext_iorq_n = 1'b1;
    #1;
    chk("R5", "ext idle, core strobe ignored", cs_n, 4'b1111);
    cyc(1);

    // R6 release ordering
    ext_req_n = 1'b1;
    cyc(2);
    chk("R6", "ack held before 3rd edge", bus_ack_n, 0);
    cyc(1);
    chk("R6", "ack dropped", bus_ack_n, 1);
    chk("R6", "drivers still off", addr_oe, 0);
    chk("R6", "hold still on", core_hold, 1);
    chk("R5", "core source after grant", cs_n, 4'b1110);
    cyc(1);
    chk("R6", "drivers back", {addr_oe, ctl_oe, rw_oe, data_oe}, 4'b1111);
    chk("R6", "hold released", core_hold, 0);

    // R7 withdrawal before idle
    core_idle = 1'b0;
    ext_req_n = 1'b0;
    cyc(3);
    chk("R7", "hold raised", core_hold, 1);
    ext_req_n = 1'b1;
    cyc(2);
    chk("R7", "hold before 3rd edge", core_hold, 1);
    cyc(1);
    chk("R7", "hold dropped", core_hold, 0);
    core_idle = 1'b1;
    cyc(3);
    chk("R7", "no ack", bus_ack_n, 1);

    // R3 idle already high: grant one edge after hold
    ext_req_n = 1'b0;
    cyc(3);
    chk("R3", "hold, no ack yet", {core_hold, bus_ack_n}, 2'b11);
    cyc(1);
    chk("R3", "ack with idle ready", bus_ack_n, 0);
    ext_req_n = 1'b1;
    cyc(4);
    chk("R6", "second release", {bus_ack_n, core_hold, addr_oe}, 3'b101);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule